// File: doc/BRIEF.md
# Early-Termination Report Queue

This block keeps a record of transfers that a data mover closed before their programmed length, which happens when a streaming source marks the end of a packet early. For each such transfer it stores the transfer ID together with the byte count that was really moved. Software can then work out the unmoved remainder itself. A transfer only produces such a record when its partial-report enable was set at the moment it was submitted, and the block keeps that choice for each ID.

Every transfer end, early or not, sets the transfer's own bit in a completion bitmask and pulses an end-of-transfer interrupt. The top bit of that bitmask shows whether early-termination records are waiting. Software drains the queue by reading the length word, then the ID word, and then checking the top bit again, repeating until it clears. Reading the ID word removes the oldest record. If the queue is full, new records are dropped and a sticky overflow flag is raised.

Top module: `prq_report_queue`

## Requirements
- R1: After a synchronous active-low reset the queue is empty, the completion bitmask and overflow flag are zero, all four readback words read 0 and `eot_irq` is low.
- R2: A pulse on `sub_valid` records `sub_partial_en` as the partial-report enable of `sub_id`. A later submission of the same ID replaces the earlier value.
- R3: A transfer end (`end_valid`) with `end_early`=1 whose ID has its enable set queues the pair (`end_id`, `end_len`). An end with `end_early`=0, or with the enable cleared, queues nothing.
- R4: Reading with `rd_sel`=0 returns the oldest record's length, zero-extended. This read does not remove the record.
- R5: Reading with `rd_sel`=1 returns the oldest record's ID, zero-extended, and removes that record at the clock edge. Records come out in the order they went in.
- R6: Reading with `rd_sel`=2 returns the completion bitmask. Bit n (n < 2**ID_W) is set once transfer n has ended, whether or not it ended early. Bit 31 is 1 while the queue is not empty. This read clears the bitmask bits it returned, but a bit set in the same cycle is kept.
- R7: Every transfer end raises `eot_irq` for exactly the following clock cycle.
- R8: While the queue is empty, reads with `rd_sel`=0 or 1 return 0 and change no state.
- R9: A record that arrives while the queue holds DEPTH entries is dropped, even if a pop happens in the same cycle. The drop sets bit 0 of the status word (`rd_sel`=3), and that bit stays set until the status word is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sub_valid | input | 1 | Transfer submission strobe |
| sub_id | input | ID_W | ID of the submitted transfer |
| sub_partial_en | input | 1 | Partial-report enable of the submitted transfer |
| end_valid | input | 1 | Transfer end strobe from the data mover |
| end_id | input | ID_W | ID of the ending transfer |
| end_early | input | 1 | Transfer ended before its programmed length |
| end_len | input | LEN_W | Bytes actually moved |
| rd_en | input | 1 | Register read strobe (side effects at the clock edge) |
| rd_sel | input | 2 | Word select: 0 length, 1 ID, 2 completion bitmask, 3 status |
| rd_data | output | 32 | Combinational readback of the selected word |
| eot_irq | output | 1 | End-of-transfer interrupt pulse |

## Verification
The bench builds the block with DEPTH=4, ID_W=4 and LEN_W=24. The small depth lets a handful of back-to-back early terminations fill the queue, so the drop path, the sticky overflow flag and the case of a push arriving while full in the same cycle as a pop can all be reached in a few dozen cycles. With 16 IDs, every completion bit sits well below bit 31, so the pending flag can be checked apart from the per-ID bits.

// File: rtl/prq_pkg.sv
// Shared definitions for the early-termination report queue.
// Assumes a 32-bit readback word, with the pending flag in its top bit.
package prq_pkg;
    localparam int REG_W    = 32;
    localparam int PEND_BIT = 31;
    localparam int OVF_BIT  = 0;

    typedef enum logic [1:0] {
        SEL_LEN  = 2'd0,
        SEL_ID   = 2'd1,
        SEL_DONE = 2'd2,
        SEL_STAT = 2'd3
    } prq_sel_e;
endpackage

// File: rtl/prq_enable_table.sv
// Per-ID table of partial-report enables, captured at submission.
// Assumes at most one submission per cycle. A lookup in the same cycle as
// a submission to that ID sees the old value.
module prq_enable_table #(
    parameter int ID_W    = 4,
    localparam int NUM_IDS = 1 << ID_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sub_valid,
    input  logic [ID_W-1:0] sub_id,
    input  logic            sub_en,
    input  logic [ID_W-1:0] look_id,
    output logic            look_en
);
    logic [NUM_IDS-1:0] en_q;

    for (genvar i = 0; i < NUM_IDS; i++) begin : g_slot
        // Hold the enable of ID i until it is resubmitted
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q[i] <= 1'b0;
            else if (sub_valid && (sub_id == ID_W'(i)))
                en_q[i] <= sub_en;
        end
    end

    // Look up the enable of the ending transfer
    always_comb look_en = en_q[look_id];
endmodule

// File: rtl/prq_fifo.sv
// Small FIFO for report records, with occupancy output.
// Assumes DEPTH >= 2. A push while full is ignored, even with a pop in the
// same cycle. A pop while empty is ignored.
module prq_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 28,
    localparam int AW   = $clog2(DEPTH),
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [FW-1:0] fill
);
    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic          do_push, do_pop;

    // Qualify requests against the current occupancy
    always_comb begin
        empty   = (fill == '0);
        full    = (fill == FW'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = mem_q[rd_q];
    end

    // Write accepted records into storage
    always_ff @(posedge clk) begin
        if (do_push)
            mem_q[wr_q] <= din;
    end

    // Advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
            fill <= '0;
        end else begin
            if (do_push)
                wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (do_pop)
                rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            if (do_push && !do_pop)
                fill <= fill + 1'b1;
            else if (do_pop && !do_push)
                fill <= fill - 1'b1;
        end
    end
endmodule

// File: rtl/prq_done_tracker.sv
// Completion bitmask and end-of-transfer interrupt pulse.
// Assumes one transfer end per cycle. The clear request wipes only the bits
// held before this edge, so a bit set in the same cycle survives.
module prq_done_tracker #(
    parameter int ID_W    = 4,
    localparam int NUM_IDS = 1 << ID_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_valid,
    input  logic [ID_W-1:0]    set_id,
    input  logic               clr,
    output logic [NUM_IDS-1:0] done_bits,
    output logic               irq
);
    logic [NUM_IDS-1:0] set_mask;

    // Decode the ending ID to a one-hot mask
    always_comb begin
        for (int i = 0; i < NUM_IDS; i++)
            set_mask[i] = set_valid && (set_id == ID_W'(i));
    end

    // Update the bitmask and register the interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_bits <= '0;
            irq       <= 1'b0;
        end else begin
            done_bits <= (clr ? '0 : done_bits) | set_mask;
            irq       <= set_valid;
        end
    end
endmodule

// File: rtl/prq_report_queue.sv
// Early-termination report queue: logs (ID, moved length) for transfers that
// ended early with their partial-report enable set, and provides readback
// with pop-on-ID-read, a completion bitmask carrying a pending flag, and a
// sticky overflow status.
// Assumes ID_W <= 4 so the completion bits stay below the pending flag, and
// LEN_W + ID_W fits the record width.
module prq_report_queue
    import prq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ID_W  = 4,
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sub_valid,
    input  logic [ID_W-1:0]  sub_id,
    input  logic             sub_partial_en,
    input  logic             end_valid,
    input  logic [ID_W-1:0]  end_id,
    input  logic             end_early,
    input  logic [LEN_W-1:0] end_len,
    input  logic             rd_en,
    input  logic [1:0]       rd_sel,
    output logic [31:0]      rd_data,
    output logic             eot_irq
);
    localparam int NUM_IDS = 1 << ID_W;
    localparam int REC_W   = ID_W + LEN_W;
    localparam int FW      = $clog2(DEPTH + 1);

    logic               en_hit;
    logic               push_req;
    logic               pop_req;
    logic               done_clr;
    logic               stat_rd;
    logic [REC_W-1:0]   head;
    logic               rq_empty, rq_full;
    logic [FW-1:0]      rq_fill;
    logic [NUM_IDS-1:0] done_bits;
    logic               ovf_q;
    prq_sel_e           sel;

    prq_enable_table #(.ID_W(ID_W)) u_enables (
        .clk     (clk),
        .rst_n   (rst_n),
        .sub_valid(sub_valid),
        .sub_id  (sub_id),
        .sub_en  (sub_partial_en),
        .look_id (end_id),
        .look_en (en_hit)
    );

    // Decode requests from the transfer end and the read strobe
    always_comb begin
        sel      = prq_sel_e'(rd_sel);
        push_req = end_valid && end_early && en_hit;
        pop_req  = rd_en && (sel == SEL_ID);
        done_clr = rd_en && (sel == SEL_DONE);
        stat_rd  = rd_en && (sel == SEL_STAT);
    end

    prq_fifo #(.DEPTH(DEPTH), .W(REC_W)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push_req),
        .din  ({end_id, end_len}),
        .pop  (pop_req),
        .dout (head),
        .empty(rq_empty),
        .full (rq_full),
        .fill (rq_fill)
    );

    prq_done_tracker #(.ID_W(ID_W)) u_done (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_valid(end_valid),
        .set_id   (end_id),
        .clr      (done_clr),
        .done_bits(done_bits),
        .irq      (eot_irq)
    );

    // Sticky overflow: set on a dropped record, cleared by a status read
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (push_req && rq_full)
            ovf_q <= 1'b1;
        else if (stat_rd)
            ovf_q <= 1'b0;
    end

    // Readback multiplexer; empty-queue words read as zero
    always_comb begin
        rd_data = '0;
        unique case (sel)
            SEL_LEN:  if (!rq_empty) rd_data[LEN_W-1:0] = head[LEN_W-1:0];
            SEL_ID:   if (!rq_empty) rd_data[ID_W-1:0]  = head[REC_W-1:LEN_W];
            SEL_DONE: begin
                rd_data[NUM_IDS-1:0] = done_bits;
                rd_data[PEND_BIT]    = !rq_empty;
            end
            SEL_STAT: rd_data[OVF_BIT] = ovf_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/prq_report_queue_chk.sv
// Property checker for the early-termination report queue, bound to the top.
// Assumes it observes the queue occupancy, the full flag and the overflow flag.
module prq_report_queue_chk #(
    parameter int DEPTH = 8,
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          end_valid,
    input logic          end_early,
    input logic          eot_irq,
    input logic          rd_en,
    input logic [1:0]    rd_sel,
    input logic [FW-1:0] rq_fill,
    input logic          rq_full,
    input logic          push_req,
    input logic          ovf_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (rq_fill == '0) && !ovf_q && !eot_irq);

    // R7
    irq_follows_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_valid |=> eot_irq);

    // R7
    irq_without_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !end_valid |=> !eot_irq);

    // R3
    no_push_on_normal_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_valid && !end_early && !rd_en) |=> $stable(rq_fill));

    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_sel == 2'd1) && (rq_fill == '0) && !push_req) |=> (rq_fill == '0));

    // R9
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rq_fill <= FW'(DEPTH));

    // R9
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && rq_full) |=> ovf_q);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(rd_en && (rd_sel == 2'd3))) |=> ovf_q);
endmodule

bind prq_report_queue prq_report_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .end_valid(end_valid),
    .end_early(end_early),
    .eot_irq  (eot_irq),
    .rd_en    (rd_en),
    .rd_sel   (rd_sel),
    .rq_fill  (rq_fill),
    .rq_full  (rq_full),
    .push_req (push_req),
    .ovf_q    (ovf_q)
);

// File: tb/prq_report_queue_tb_top.sv
// Self-checking bench for the early-termination report queue.
module prq_report_queue_tb_top;
    localparam int DEPTH = 4;
    localparam int ID_W  = 4;
    localparam int LEN_W = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sub_valid = 1'b0;
    logic [ID_W-1:0]  sub_id = '0;
    logic             sub_partial_en = 1'b0;
    logic             end_valid = 1'b0;
    logic [ID_W-1:0]  end_id = '0;
    logic             end_early = 1'b0;
    logic [LEN_W-1:0] end_len = '0;
    logic             rd_en = 1'b0;
    logic [1:0]       rd_sel = '0;
    logic [31:0]      rd_data;
    logic             eot_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit all_done = 1'b0;

    prq_report_queue #(.DEPTH(DEPTH), .ID_W(ID_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .sub_valid(sub_valid), .sub_id(sub_id), .sub_partial_en(sub_partial_en),
        .end_valid(end_valid), .end_id(end_id), .end_early(end_early), .end_len(end_len),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .eot_irq(eot_irq)
    );

    always #5 clk = ~clk;

    // Vector fields: {id[4], len[24], enable, early}
    localparam logic [29:0] VEC [6] = '{
        {4'd3,  24'd100,    1'b1, 1'b1},
        {4'd5,  24'd4096,   1'b1, 1'b0},
        {4'd7,  24'd12,     1'b0, 1'b1},
        {4'd0,  24'hFFFFFF, 1'b1, 1'b1},
        {4'd15, 24'd1,      1'b1, 1'b1},
        {4'd9,  24'd64,     1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic read_reg(input logic [1:0] s, output logic [31:0] d);
        rd_en = 1'b1; rd_sel = s;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic submit(input logic [ID_W-1:0] id, input logic en);
        sub_valid = 1'b1; sub_id = id; sub_partial_en = en;
        @(negedge clk);
        sub_valid = 1'b0;
    endtask

    task automatic finish_xfer(input logic [ID_W-1:0] id, input logic [LEN_W-1:0] len,
                               input logic early);
        end_valid = 1'b1; end_id = id; end_len = len; end_early = early;
        @(negedge clk);
        end_valid = 1'b0; end_early = 1'b0;
        check("R7 eot_irq after end", {31'd0, eot_irq}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!all_done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq low", {31'd0, eot_irq}, 32'd0);
        for (int s = 0; s < 4; s++) begin
            read_reg(2'(s), d);
            check("R1 reset readback", d, 32'd0);
        end

        // Vector table walk
        for (int v = 0; v < 6; v++) begin
            logic [ID_W-1:0]  id;
            logic [LEN_W-1:0] len;
            logic             en, early, q;
            {id, len, en, early} = VEC[v];
            q = en && early;
            submit(id, en);
            finish_xfer(id, len, early);
            read_reg(2'd2, d);
            check("R6 done bit and pending", d, (32'd1 << id) | (32'(q) << 31));
            if (q) begin
                read_reg(2'd0, d);
                check("R4 length of record", d, 32'(len));
                read_reg(2'd1, d);
                check("R5 id of record", d, 32'(id));
            end else begin
                read_reg(2'd1, d);
                check("R3 nothing queued", d, 32'd0);
            end
            read_reg(2'd2, d);
            check("R6 done cleared and queue drained", d, 32'd0);
        end

        // R5 ordering, R4 no pop on length read
        for (int i = 1; i <= 3; i++) submit(4'(i), 1'b1);
        for (int i = 1; i <= 3; i++) finish_xfer(4'(i), 24'(11 * i), 1'b1);
        read_reg(2'd2, d);
        check("R6 bitmask with pending", d, 32'h8000000E);
        read_reg(2'd0, d);
        check("R4 first length", d, 32'd11);
        read_reg(2'd0, d);
        check("R4 length read again not popped", d, 32'd11);
        read_reg(2'd1, d);
        check("R5 first id", d, 32'd1);
        read_reg(2'd0, d);
        check("R5 second length", d, 32'd22);
        read_reg(2'd1, d);
        check("R5 second id", d, 32'd2);
        read_reg(2'd1, d);
        check("R5 third id", d, 32'd3);

        // R8 empty reads
        read_reg(2'd1, d);
        check("R8 empty id read", d, 32'd0);
        read_reg(2'd0, d);
        check("R8 empty length read", d, 32'd0);
        read_reg(2'd2, d);
        check("R8 pending stays clear", d, 32'd0);
        submit(4'd6, 1'b1);
        finish_xfer(4'd6, 24'd77, 1'b1);
        read_reg(2'd0, d);
        check("R8 queue works after empty reads", d, 32'd77);
        read_reg(2'd1, d);
        check("R8 id after empty reads", d, 32'd6);

        // R2 resubmission replaces enable
        submit(4'd1, 1'b0);
        finish_xfer(4'd1, 24'd5, 1'b1);
        read_reg(2'd2, d);
        check("R2 disabled resubmit not queued", d, 32'h00000042);

        // R6 bit set in the same cycle as a clear survives
        end_valid = 1'b1; end_id = 4'd2; end_early = 1'b0; end_len = 24'd8;
        rd_en = 1'b1; rd_sel = 2'd2;
        #1 d = rd_data;
        @(negedge clk);
        end_valid = 1'b0; rd_en = 1'b0;
        check("R6 read during set", d, 32'd0);
        read_reg(2'd2, d);
        check("R6 same-cycle set kept", d, 32'h00000004);

        // R9 overflow
        for (int i = 4; i <= 10; i++) submit(4'(i), 1'b1);
        for (int i = 4; i <= 9; i++) finish_xfer(4'(i), 24'(100 + i), 1'b1);
        read_reg(2'd3, d);
        check("R9 overflow flag set", d, 32'd1);
        read_reg(2'd3, d);
        check("R9 overflow cleared by read", d, 32'd0);
        end_valid = 1'b1; end_id = 4'd10; end_early = 1'b1; end_len = 24'd999;
        rd_en = 1'b1; rd_sel = 2'd1;
        #1 d = rd_data;
        @(negedge clk);
        end_valid = 1'b0; end_early = 1'b0; rd_en = 1'b0;
        check("R9 pop while full returns head", d, 32'd4);
        read_reg(2'd3, d);
        check("R9 push during pop while full dropped", d, 32'd1);
        for (int i = 5; i <= 7; i++) begin
            read_reg(2'd0, d);
            check("R9 kept length", d, 32'(100 + i));
            read_reg(2'd1, d);
            check("R9 kept id", d, 32'(i));
        end
        read_reg(2'd1, d);
        check("R9 dropped records absent", d, 32'd0);
        read_reg(2'd2, d);
        check("R6 bitmask after overflow run", d, 32'h000007F0);

        all_done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule